// File: doc/BRIEF.md
# Thread Serial Number Allocator

This block keeps a fixed pool of 8-bit thread serial codes and hands them out on request. Every pool entry pairs a constant code with a single free/used flag. An allocate strobe takes the lowest-indexed free entry, marks it used and reports its code one cycle later. When every entry is in use, the block reports busy and leaves its state alone. A release strobe carries a code value. The block looks that value up among the pool codes and frees the entry that holds it.

The pool codes are spread out and not contiguous, and they are produced from a fixed seed table. A build parameter removes the first fourteen seed codes, which leaves a pool of 32 entries. The data flow here is a single request and its response, so the interface has no back-pressure. Requests are accepted on every clock. The response is a one-cycle valid pulse that cannot be stalled, and the requester must capture it when it appears.

Top module: `tsn_alloc`

## Requirements
- R1: During reset and in the first cycle after it, `rsp_valid` and `rsp_busy` are low, and every pool entry starts out free.
- R2: Full pool seed order, index i from 0 to 45. Indices 0-13 hold 0x04+8*(i/2)+(i%2). Indices 14-27 hold 0x88+16*((i-14)/2)+(i%2). Indices 28-43 hold 0x08+16*((i-28)/2)+(i%2). Indices 44-45 hold 0x80+(i-44).
- R3: An allocate strobe in cycle t gives `rsp_valid` high in cycle t+1, with the code of the lowest-indexed free entry, and marks that entry used. `rsp_valid` is low in any cycle that does not follow an allocate strobe.
- R4: An allocate with no free entry gives `rsp_valid`=1, `rsp_busy`=1 and `rsp_code`=0x00, and changes no entry.
- R5: A release whose code matches a pool entry marks that entry free. Releasing an entry that is already free leaves the pool as it was, so the code can only be handed out once.
- R6: A release whose code matches no pool entry changes nothing and produces no response.
- R7: When allocate and release arrive in the same cycle, the release is applied first. The entry it frees can therefore be granted in that same cycle if it is the lowest free entry.
- R8: With `SHORT_POOL`=1 the pool is the full table without its first 14 codes. It holds 32 entries, starts at 0x88, and reports busy on the 33rd allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocate strobe, one request per cycle |
| free_req | input | 1 | Release strobe |
| free_code | input | 8 | Code being released |
| rsp_valid | output | 1 | One-cycle pulse after every allocate strobe |
| rsp_code | output | 8 | Granted code; 0x00 when busy |
| rsp_busy | output | 1 | Allocation failed: pool exhausted |

## Verification
Allocation and release can land in the same clock. The case that matters is a full pool, where only the release in that cycle can make the grant succeed. The bench fills the pool and then, for every odd-indexed entry, strobes release of that entry's code together with an allocate. It expects that exact code back and no busy flag. A second case frees a higher entry first and then pairs a lower release with an allocate. The bench expects the lower code, which shows the release lands before the priority scan.

// File: rtl/tsn_pkg.sv
package tsn_pkg;
  localparam int CODE_W = 8;
  localparam int FULL_N = 46;
  localparam int DROP_N = 14;

  // Seed code for full-table index idx: four groups of code pairs.
  function automatic logic [CODE_W-1:0] seed_code(input int idx);
    int grp;
    int lsb;
    logic [CODE_W-1:0] base;
    lsb = idx % 2;
    if (idx < 14) begin
      grp  = idx / 2;
      base = CODE_W'(4 + 8 * grp);
    end else if (idx < 28) begin
      grp  = (idx - 14) / 2;
      base = CODE_W'(136 + 16 * grp);
    end else if (idx < 44) begin
      grp  = (idx - 28) / 2;
      base = CODE_W'(8 + 16 * grp);
    end else begin
      base = CODE_W'(128);
    end
    return base | CODE_W'(lsb);
  endfunction
endpackage

// File: rtl/tsn_first.sv
module tsn_first #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IW'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsn_match.sv
module tsn_match #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic [N*W-1:0] codes,
  input  logic [W-1:0]   key,
  output logic [N-1:0]   eq
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = (codes[g*W +: W] == key);
  end
endmodule

// File: rtl/tsn_alloc.sv
module tsn_alloc #(
  parameter bit SHORT_POOL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alloc_req,
  input  logic       free_req,
  input  logic [7:0] free_code,
  output logic       rsp_valid,
  output logic [7:0] rsp_code,
  output logic       rsp_busy
);
  import tsn_pkg::*;

  localparam int SKIP   = SHORT_POOL ? DROP_N : 0;
  localparam int POOL_N = FULL_N - SKIP;
  localparam int IDX_W  = $clog2(POOL_N);

  logic [POOL_N*CODE_W-1:0] codes;
  logic [POOL_N-1:0] free_q, free_n, eq, rel_oh, avail, pick_oh;
  logic [IDX_W-1:0]  rel_idx, pick_idx;
  logic              rel_any, pick_any;

  for (genvar g = 0; g < POOL_N; g++) begin : g_seed
    assign codes[g*CODE_W +: CODE_W] = seed_code(g + SKIP);
  end

  tsn_match #(.N(POOL_N), .W(CODE_W)) u_match (
    .codes(codes), .key(free_code), .eq(eq)
  );

  // Release chooses the first entry holding the value.
  tsn_first #(.N(POOL_N)) u_relpick (
    .req(eq & {POOL_N{free_req}}), .grant(rel_oh), .idx(rel_idx), .any(rel_any)
  );

  // Release lands before the allocation scan.
  assign avail = free_q | rel_oh;

  tsn_first #(.N(POOL_N)) u_allocpick (
    .req(avail), .grant(pick_oh), .idx(pick_idx), .any(pick_any)
  );

  always_comb begin
    free_n = avail;
    if (alloc_req && pick_any) free_n = avail & ~pick_oh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q    <= '1;
      rsp_valid <= 1'b0;
      rsp_busy  <= 1'b0;
      rsp_code  <= '0;
    end else begin
      free_q    <= free_n;
      rsp_valid <= alloc_req;
      rsp_busy  <= alloc_req && !pick_any;
      rsp_code  <= (alloc_req && pick_any) ? codes[int'(pick_idx)*CODE_W +: CODE_W] : '0;
    end
  end

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> rsp_valid);
  // R3
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_req |=> !rsp_valid && !rsp_busy);
  // R3
  take_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && !free_req && (free_q != '0) |=>
      !rsp_busy && ($countones(free_q) == $countones($past(free_q)) - 1));
  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && !free_req && (free_q == '0) |=>
      rsp_busy && (rsp_code == '0) && (free_q == '0));
  // R6
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_req && !alloc_req && (eq == '0) |=> free_q == $past(free_q));
  // R5
  rel_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_req && !alloc_req && rel_any |=> free_q[$past(rel_idx)]);
endmodule

// File: tb/sim_tsn_alloc.sv
module sim_tsn_alloc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 1'b0, free_req = 1'b0;
  logic [7:0] free_code = '0;
  logic v0, b0, v1, b1;
  logic [7:0] c0, c1;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tsn_alloc #(.SHORT_POOL(1'b0)) u0 (.clk, .rst_n, .alloc_req, .free_req, .free_code,
    .rsp_valid(v0), .rsp_code(c0), .rsp_busy(b0));
  tsn_alloc #(.SHORT_POOL(1'b1)) u1 (.clk, .rst_n, .alloc_req, .free_req, .free_code,
    .rsp_valid(v1), .rsp_code(c1), .rsp_busy(b1));

  function automatic int code_of(input int i);
    if (i < 14)      return 4 + 8 * (i / 2) + (i % 2);
    else if (i < 28) return 'h88 + 16 * ((i - 14) / 2) + (i % 2);
    else if (i < 44) return 'h08 + 16 * ((i - 28) / 2) + (i % 2);
    else             return 'h80 + (i - 44);
  endfunction

  function automatic bit in_table(input int v);
    for (int i = 0; i < 46; i++) if (code_of(i) == v) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit a, input bit r, input int c);
    alloc_req = a; free_req = r; free_code = 8'(c);
    @(negedge clk);
    alloc_req = 0; free_req = 0; free_code = '0;
  endtask

  task automatic expect_code(input string req, input int exp);
    chk(v0 && !b0 && (int'(c0) == exp), req, {v0, b0, c0}, {1'b1, 1'b0, 8'(exp)});
  endtask

  task automatic expect_busy(input string req);
    chk(v0 && b0 && (c0 == 0), req, {v0, b0, c0}, 10'h300);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!v0 && !b0 && !v1 && !b1, "R1 reset", {v0, b0}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!v0 && !b0, "R1 after reset", {v0, b0}, 0);
    // Fill: full pool in seed order; short pool runs dry after 32
    for (int k = 0; k < 46; k++) begin
      step(1, 0, 0);
      expect_code("R2 fill order", code_of(k));
      if (k < 32)
        chk(v1 && !b1 && int'(c1) == code_of(k + 14), "R8 short pool", c1, code_of(k + 14));
      else
        chk(v1 && b1 && c1 == 0, "R8 short busy", {v1, b1, c1}, 10'h300);
    end
    step(1, 0, 0);
    expect_busy("R4 exhausted");
    // R6: every value outside the table is ignored
    for (int v = 0; v < 256; v++) begin
      if (!in_table(v)) begin
        step(0, 1, v);
        chk(!v0 && !b0, "R6 no response", {v0, b0}, 0);
      end
    end
    step(1, 0, 0);
    expect_busy("R6 nothing freed");
    // Per-entry sweep: even separately, odd in the same cycle (R7)
    for (int k = 0; k < 46; k++) begin
      if (k % 2 == 0) begin
        step(0, 1, code_of(k));
        chk(!v0, "R3 no pulse on release", v0, 0);
        step(1, 0, 0);
        expect_code("R5 release then alloc", code_of(k));
      end else begin
        step(1, 1, code_of(k));
        expect_code("R7 same-cycle on full pool", code_of(k));
      end
    end
    // Lowest-index priority regardless of release order
    step(0, 1, code_of(30)); step(0, 1, code_of(3)); step(0, 1, code_of(10));
    step(1, 0, 0); expect_code("R3 lowest first", code_of(3));
    step(1, 0, 0); expect_code("R3 lowest second", code_of(10));
    step(1, 0, 0); expect_code("R3 lowest third", code_of(30));
    step(1, 0, 0); expect_busy("R4 after drain");
    // Double release frees once
    step(0, 1, code_of(7)); step(0, 1, code_of(7));
    step(1, 0, 0); expect_code("R5 double release", code_of(7));
    step(1, 0, 0); expect_busy("R5 single copy");
    // Same-cycle release of lower entry beats an already-free higher one
    step(0, 1, code_of(20));
    step(1, 1, code_of(2)); expect_code("R7 release first", code_of(2));
    step(1, 0, 0); expect_code("R7 higher kept", code_of(20));
    step(1, 0, 0); expect_busy("R4 final");
    step(0, 0, 0);
    chk(!v0 && !b0, "R3 idle", {v0, b0}, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule